// File: doc/BRIEF.md
# Four-State Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small table of per-branch history entries. The table is indexed by a few low bits of the branch's program counter. A fetch stage presents a PC on the lookup port and gets back a taken bit in the same cycle. When the branch later resolves, the execute stage presents the branch PC and its real outcome on the update port. The addressed entry then moves to its next state at the following clock edge. The block does not compute branch targets and does not flush the pipeline.

Each entry is a four-state machine. The states are **SNT** (strongly not taken), **LNT** (leaning not taken), **LT** (leaning taken) and **ST** (strongly taken). These transitions differ from a plain saturating counter. The reset state LNT jumps straight to one of the two strong states on its first resolved outcome. A taken outcome in SNT climbs back only as far as LNT. The named transitions are:

- LNT-up: LNT, taken → ST
- LNT-down: LNT, not taken → SNT
- ST-hold: ST, taken → ST
- ST-drop: ST, not taken → LT
- LT-up: LT, taken → ST
- LT-drop: LT, not taken → SNT
- SNT-hold: SNT, not taken → SNT
- SNT-wake: SNT, taken → LNT

A parameter selects a simpler two-state variant instead. It uses only LNT and LT:

- Two-up: LNT, taken → LT
- Two-stay: LNT, not taken → LNT
- Two-hold: LT, taken → LT
- Two-down: LT, not taken → LNT

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every table entry is in LNT, so every lookup returns not taken until an update touches that entry.
- R2: An update with outcome taken to an entry in LNT moves it to ST (LNT-up).
- R3: An update with outcome not taken to an entry in LNT moves it to SNT (LNT-down).
- R4: From ST, a taken update keeps ST (ST-hold) and a not-taken update moves to LT (ST-drop).
- R5: From LT, a taken update moves to ST (LT-up) and a not-taken update moves to SNT (LT-drop).
- R6: From SNT, a not-taken update keeps SNT (SNT-hold) and a taken update moves to LNT (SNT-wake).
- R7: `pred_taken` is 1 exactly when the entry selected by `pred_pc` is in LT or ST, and it is combinational in the lookup PC.
- R8: The entry is selected by PC bits [IDX_LO+IDX_W-1:IDX_LO], which are [5:2] by default. All other PC bits are ignored. An update changes only the entry it selects.
- R9: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from before the update.
- R10: When `upd_valid` is low, no entry changes state.
- R11: With FOUR_STATE = 0, entries follow Two-up, Two-stay, Two-hold and Two-down, and LT predicts taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction for `pred_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch outcome is present |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The bench builds two copies of the block. Both have the default 16-entry table indexed by PC bits [5:2]. One copy uses the four-state machine and the other uses the two-state variant. Both are driven with the same stimulus and compared against two behavioural models every cycle.

Sixteen entries keep index collisions frequent under random PCs. This makes same-cycle lookup and update to one entry a common case. Each random PC also sets its upper bits, so aliasing across those bits is exercised as well. Directed sequences walk a single entry through every named transition before the random phase begins.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Bit 1 of the encoding is the predicted direction.
    typedef enum logic [1:0] {
        DIR_SNT = 2'b00,
        DIR_LNT = 2'b01,
        DIR_LT  = 2'b10,
        DIR_ST  = 2'b11
    } dir_state_e;

    localparam dir_state_e DIR_RESET = DIR_LNT;

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int PC_W   = 32,
    parameter int IDX_LO = 2,
    parameter int IDX_W  = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = pc[IDX_LO +: IDX_W];
    end
endmodule

// File: rtl/bp_next.sv
module bp_next
    import bp_pkg::*;
#(
    parameter bit FOUR_STATE = 1'b1
) (
    input  dir_state_e cur,
    input  logic       taken,
    output dir_state_e nxt
);
    generate
        if (FOUR_STATE) begin : g_four
            always_comb begin
                nxt = DIR_RESET;
                unique case (cur)
                    DIR_LNT: nxt = taken ? DIR_ST  : DIR_SNT;  // LNT-up / LNT-down
                    DIR_ST:  nxt = taken ? DIR_ST  : DIR_LT;   // ST-hold / ST-drop
                    DIR_LT:  nxt = taken ? DIR_ST  : DIR_SNT;  // LT-up / LT-drop
                    DIR_SNT: nxt = taken ? DIR_LNT : DIR_SNT;  // SNT-wake / SNT-hold
                    default: nxt = DIR_RESET;
                endcase
            end
        end else begin : g_two
            always_comb begin
                nxt = DIR_RESET;
                unique case (cur)
                    DIR_LNT: nxt = taken ? DIR_LT : DIR_LNT;   // Two-up / Two-stay
                    DIR_LT:  nxt = taken ? DIR_LT : DIR_LNT;   // Two-hold / Two-down
                    default: nxt = DIR_RESET;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/bp_entry.sv
module bp_entry
    import bp_pkg::*;
#(
    parameter bit FOUR_STATE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       taken,
    output dir_state_e state
);
    dir_state_e nxt;

    bp_next #(.FOUR_STATE(FOUR_STATE)) u_next (
        .cur   (state),
        .taken (taken),
        .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIR_RESET;
        end else if (wr) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IDX_LO     = 2,
    parameter int IDX_W      = 4,
    parameter bit FOUR_STATE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]     pidx;
    logic [IDX_W-1:0]     uidx;
    dir_state_e           table_q [ENTRIES];
    logic [ENTRIES*2-1:0] st_flat;
    dir_state_e           sel_state;

    bp_index #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_pidx (
        .pc  (pred_pc),
        .idx (pidx)
    );

    bp_index #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_uidx (
        .pc  (upd_pc),
        .idx (uidx)
    );

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            logic wr_e;
            always_comb begin
                wr_e = upd_valid && (uidx == IDX_W'(e));
            end
            bp_entry #(.FOUR_STATE(FOUR_STATE)) u_entry (
                .clk   (clk),
                .rst_n (rst_n),
                .wr    (wr_e),
                .taken (upd_taken),
                .state (table_q[e])
            );
            assign st_flat[e*2 +: 2] = table_q[e];
        end
    endgenerate

    // The lookup reads the registered state, so a same-cycle update is not visible yet.
    always_comb begin
        sel_state = table_q[pidx];
    end

    always_comb begin
        unique case (sel_state)
            DIR_ST, DIR_LT:   pred_taken = 1'b1;
            DIR_LNT, DIR_SNT: pred_taken = 1'b0;
            default:          pred_taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bp_checker.sv
module bp_checker
    import bp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IDX_LO     = 2,
    parameter int IDX_W      = 4,
    parameter bit FOUR_STATE = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       upd_valid,
    input logic [PC_W-1:0]            upd_pc,
    input logic                       upd_taken,
    input logic [(1<<IDX_W)*2-1:0]    st_flat
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int FW      = ENTRIES * 2;

    logic [IDX_W-1:0] uidx;
    logic [IDX_W-1:0] last_idx;
    logic [1:0]       cur_u;
    logic [1:0]       after_u;
    logic [FW-1:0]    keep_mask;

    always_comb begin
        uidx      = upd_pc[IDX_LO +: IDX_W];
        cur_u     = st_flat[int'(uidx)*2 +: 2];
        after_u   = st_flat[int'(last_idx)*2 +: 2];
        keep_mask = ~(FW'(2'b11) << (int'(last_idx)*2));
    end

    always_ff @(posedge clk) begin
        last_idx <= uidx;
    end

    // R10: nothing moves without an update
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(st_flat));

    // R8: an update leaves every other entry untouched
    p_single_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((st_flat ^ $past(st_flat)) & keep_mask) == '0);

    generate
        if (FOUR_STATE) begin : g_four_chk
            p_lnt_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && cur_u == DIR_LNT && upd_taken) |=> after_u == DIR_ST);
            p_lnt_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && cur_u == DIR_LNT && !upd_taken) |=> after_u == DIR_SNT);
            p_st_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && cur_u == DIR_ST && !upd_taken) |=> after_u == DIR_LT);
            p_lt_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && cur_u == DIR_LT && !upd_taken) |=> after_u == DIR_SNT);
            p_snt_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && cur_u == DIR_SNT && upd_taken) |=> after_u == DIR_LNT);
        end else begin : g_two_chk
            p_two_states_r11: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> (after_u == DIR_LNT || after_u == DIR_LT));
            p_two_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_taken) |=> after_u == DIR_LT);
        end
    endgenerate
endmodule

bind branch_dir_predictor bp_checker #(
    .PC_W       (PC_W),
    .IDX_LO     (IDX_LO),
    .IDX_W      (IDX_W),
    .FOUR_STATE (FOUR_STATE)
) u_bp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .st_flat   (st_flat)
);

// File: tb/tb_branch_dir_predictor.sv
module tb_branch_dir_predictor;
    localparam int PC_W = 32;
    localparam int N    = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_valid = 1'b0;
    logic            upd_taken = 1'b0;
    logic            pred4;
    logic            pred2;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Model states: 0 SNT, 1 LNT, 2 LT, 3 ST
    int m4 [N];
    int m2 [N];

    always #10 clk = ~clk;

    branch_dir_predictor dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred4),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    branch_dir_predictor #(.FOUR_STATE(1'b0)) dut_two (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int nxt4(int s, bit t);
        case (s)
            1: return t ? 3 : 0;
            3: return t ? 3 : 2;
            2: return t ? 3 : 0;
            default: return t ? 1 : 0;
        endcase
    endfunction

    function automatic int nxt2(int s, bit t);
        return t ? 2 : 1;
    endfunction

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc[5:2]);
    endfunction

    task automatic check(input string tag);
        bit e4, e2;
        e4 = (m4[idx_of(pred_pc)] >= 2);
        e2 = (m2[idx_of(pred_pc)] == 2);
        compared += 2;
        if (pred4 !== e4) begin
            mismatched++;
            $display("FAIL %s four-state pc=%h: pred_taken=%0b expected %0b", tag, pred_pc, pred4, e4);
        end
        if (pred2 !== e2) begin
            mismatched++;
            $display("FAIL %s/R11 two-state pc=%h: pred_taken=%0b expected %0b", tag, pred_pc, pred2, e2);
        end
    endtask

    // Drive at a falling edge, compare before the rising edge, then apply the model.
    task automatic step(input logic [PC_W-1:0] ppc, input logic [PC_W-1:0] upc,
                        input bit uv, input bit ut, input string tag);
        pred_pc   = ppc;
        upd_pc    = upc;
        upd_valid = uv;
        upd_taken = ut;
        #2;
        check(tag);
        @(posedge clk);
        if (uv) begin
            m4[idx_of(upc)] = nxt4(m4[idx_of(upc)], ut);
            m2[idx_of(upc)] = nxt2(m2[idx_of(upc)], ut);
        end
        @(negedge clk);
    endtask

    function automatic logic [PC_W-1:0] pc_for(int i, logic [PC_W-1:0] hi);
        return (hi & ~32'h3C) | (PC_W'(i) << 2);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m4[i] = 1;
            m2[i] = 1;
        end
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) step(pc_for(i, 32'h0), 32'h0, 1'b0, 1'b0, "R1 after reset");

        // Entry 3 walks the four-state transitions
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b1, "R9 LNT-up same cycle");
        step(pc_for(3, 0), pc_for(3, 0), 1'b0, 1'b0, "R2 LNT-up then R7 ST");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b1, "R4 ST-hold");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b0, "R4 ST-drop");
        step(pc_for(3, 0), pc_for(3, 0), 1'b0, 1'b0, "R7 LT predicts taken");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b1, "R5 LT-up");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b0, "R4 ST-drop again");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b0, "R5 LT-drop");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b0, "R6 SNT-hold");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b1, "R6 SNT-wake");
        step(pc_for(3, 0), pc_for(3, 0), 1'b1, 1'b0, "R3 LNT-down");
        step(pc_for(3, 0), pc_for(3, 0), 1'b0, 1'b1, "R10 idle update ignored");
        step(pc_for(3, 0), pc_for(3, 0), 1'b0, 1'b1, "R10 still SNT");
        // Aliasing: upper bits differ, same index
        step(pc_for(7, 32'hFFFF_0003), pc_for(7, 32'h1234_0001), 1'b1, 1'b1, "R8 alias update");
        step(pc_for(7, 32'h0000_0000), pc_for(0, 0), 1'b0, 1'b0, "R8 alias lookup");
        for (int i = 0; i < N; i++) step(pc_for(i, 32'hA5A5_0000), 32'h0, 1'b0, 1'b0, "R8 other entries");

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0] a, b;
            a = $urandom;
            b = ($urandom % 4 == 0) ? a : $urandom;
            step(a, b, ($urandom % 4) != 0, $urandom % 2, "R7/R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule